// File: doc/BRIEF.md
# Crosspoint Matrix Configuration Register

This block is the digital control path of a 16-input by 16-output crosspoint switch. Every output owns a 5-bit configuration word: four bits choose which input drives it and one bit turns the output on. The 80 configuration bits sit in a load chain. The chain can be filled serially, one bit per clock, so that several devices can be chained through a serial output. It can also be written one output word at a time from a 5-bit bus selected by a 4-bit output address.

A second register stage stands between the load chain and the decoders. While its hold input is low it follows the chain, one clock behind. While the hold input is high it keeps its contents, so a new pattern can be loaded without disturbing the live routing. The held words are decoded into 256 crosspoint enables, at most one per output, and 16 output enables. A chip enable freezes all loading and updating. A synchronous reset turns every output off.

Top module: `xp_matrix_cfg`

## Requirements
- R1: Output k's word occupies load-chain bits [5k+4:5k]. Bit 5k+4 is the output-enable bit and bits [5k+3:5k] give the selected input number.
- R2: With chip_en=1 and par_mode=0, each clock shifts ser_din into chain bit 0 and moves every bit one place up. After 80 shifts, the first bit sent becomes output 15's enable bit and the last bit sent becomes output 0's select LSB.
- R3: With chip_en=1 and par_mode=1, each clock writes par_data into the word of the output numbered par_addr, with par_data[4] as the enable bit and par_data[3:0] as the select. All other words are left unchanged.
- R4: With chip_en=1 and hold_upd=0, the update stage loads the load chain's contents as they stood before that clock. With hold_upd=1 the update stage keeps its value.
- R5: xp_en[16*o+i] is 1 exactly when the update stage has output o enabled with select value i. Each 16-bit group of xp_en has at most one bit set, and out_en[o] equals output o's held enable bit.
- R6: An output whose held enable bit is 0 has all 16 of its crosspoint enables at 0 and its out_en bit at 0.
- R7: ser_dout always presents load-chain bit 79.
- R8: While chip_en=0, the load chain and the update stage keep their contents, whatever the mode, data, address and hold inputs do.
- R9: When rst=1 at a clock edge, the load chain and the update stage are cleared. While rst is 1, xp_en and out_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also forces all outputs off |
| chip_en | input | 1 | 1 enables loading and updating |
| par_mode | input | 1 | 0 = serial shift, 1 = parallel word write |
| ser_din | input | 1 | Serial configuration bit |
| par_addr | input | 4 | Output number for a parallel write |
| par_data | input | 5 | Parallel word: bit 4 enable, bits 3:0 input select |
| hold_upd | input | 1 | 1 = update stage holds, 0 = update stage follows the chain |
| ser_dout | output | 1 | Top bit of the load chain, for daisy chaining |
| xp_en | output | 256 | Crosspoint enables, bit 16*o+i joins input i to output o |
| out_en | output | 16 | Per-output enable |

## Verification
The bench fills the chain serially while the update stage holds. A design that lets the stage go transparent too early shows partially shifted routings, and a design with the bit order reversed lights the wrong outputs once the hold is released. Parallel writes go to the first and last addresses and to random ones; a design that writes the wrong slot corrupts a neighbour's routing. Runs with chip_en low toggle every other input, and reset is applied in the middle of live traffic. A design that leaks load activity past the chip enable, or that only masks outputs instead of clearing state, shows stale routes afterwards. ser_dout is compared every cycle, which catches an off-by-one shift length.

// File: rtl/xp_cfg_pkg.sv
package xp_cfg_pkg;

    localparam int XP_INPUTS  = 16;
    localparam int XP_OUTPUTS = 16;

    typedef enum logic {
        LOAD_SERIAL   = 1'b0,
        LOAD_PARALLEL = 1'b1
    } load_mode_e;

    // one-hot decode of a select value, gated by the word's enable bit
    function automatic logic [XP_INPUTS-1:0] sel_onehot(
        input logic                         en,
        input logic [$clog2(XP_INPUTS)-1:0] sel
    );
        logic [XP_INPUTS-1:0] v;
        v = '0;
        for (int i = 0; i < XP_INPUTS; i++) begin
            if (en && (sel == i[$clog2(XP_INPUTS)-1:0])) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/xp_load_chain.sv
module xp_load_chain
    import xp_cfg_pkg::*;
#(
    parameter int N_OUT   = XP_OUTPUTS,
    parameter int WORD_W  = $clog2(XP_INPUTS) + 1,
    localparam int CHAIN_W = N_OUT * WORD_W,
    localparam int AW      = $clog2(N_OUT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chip_en,
    input  load_mode_e         mode,
    input  logic               ser_din,
    input  logic [AW-1:0]      par_addr,
    input  logic [WORD_W-1:0]  par_data,
    output logic [CHAIN_W-1:0] chain,
    output logic               ser_dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else if (chip_en) begin
            if (mode == LOAD_PARALLEL) begin
                for (int k = 0; k < N_OUT; k++) begin
                    if (par_addr == k[AW-1:0]) chain[k*WORD_W +: WORD_W] <= par_data;
                end
            end else begin
                chain <= {chain[CHAIN_W-2:0], ser_din};
            end
        end
    end

    assign ser_dout = chain[CHAIN_W-1];

    // R2: serial shift moves one bit per clock
    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (chip_en && mode == LOAD_SERIAL) |=>
            (chain[0] == $past(ser_din)) && (ser_dout == $past(chain[CHAIN_W-2])));

    // R3: parallel write lands in the addressed slot
    p_pwrite_r3: assert property (@(posedge clk) disable iff (rst)
        (chip_en && mode == LOAD_PARALLEL) |=>
            (chain[$past(par_addr)*WORD_W +: WORD_W] == $past(par_data)));

    // R8: no change while the chip enable is low
    p_idle_chain_r8: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> $stable(chain));

endmodule

// File: rtl/xp_update_stage.sv
module xp_update_stage #(
    parameter int CHAIN_W = 80
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chip_en,
    input  logic               hold_upd,
    input  logic [CHAIN_W-1:0] chain,
    output logic [CHAIN_W-1:0] held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (chip_en && !hold_upd) begin
            held <= chain;
        end
    end

    // R4: transparent stage follows the chain one clock late
    p_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (chip_en && !hold_upd) |=> (held == $past(chain)));

    // R4: hold keeps the routing
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        hold_upd |=> $stable(held));

    // R8: chip enable low freezes the stage
    p_idle_held_r8: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> $stable(held));

endmodule

// File: rtl/xp_decode.sv
module xp_decode
    import xp_cfg_pkg::*;
#(
    parameter int N_IN  = XP_INPUTS,
    parameter int N_OUT = XP_OUTPUTS,
    localparam int SEL_W   = $clog2(N_IN),
    localparam int WORD_W  = SEL_W + 1,
    localparam int CHAIN_W = N_OUT * WORD_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CHAIN_W-1:0]     held,
    output logic [N_IN*N_OUT-1:0]  xp_en,
    output logic [N_OUT-1:0]       out_en
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [WORD_W-1:0] word;
        logic              live;
        assign word      = held[o*WORD_W +: WORD_W];
        assign live      = word[WORD_W-1] & ~rst;
        assign out_en[o] = live;

        for (genvar i = 0; i < N_IN; i++) begin : g_in
            assign xp_en[o*N_IN + i] = live && (word[SEL_W-1:0] == i[SEL_W-1:0]);
        end

        // R5: at most one input per output
        p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
            $onehot0(xp_en[o*N_IN +: N_IN]));

        // R6: disabled output has no crosspoint
        p_off_r6: assert property (@(posedge clk) disable iff (rst)
            !out_en[o] |-> (xp_en[o*N_IN +: N_IN] == '0));
    end

endmodule

// File: rtl/xp_matrix_cfg.sv
module xp_matrix_cfg
    import xp_cfg_pkg::*;
#(
    parameter int N_IN  = XP_INPUTS,
    parameter int N_OUT = XP_OUTPUTS,
    localparam int SEL_W   = $clog2(N_IN),
    localparam int WORD_W  = SEL_W + 1,
    localparam int CHAIN_W = N_OUT * WORD_W,
    localparam int AW      = $clog2(N_OUT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  chip_en,
    input  logic                  par_mode,
    input  logic                  ser_din,
    input  logic [AW-1:0]         par_addr,
    input  logic [WORD_W-1:0]     par_data,
    input  logic                  hold_upd,
    output logic                  ser_dout,
    output logic [N_IN*N_OUT-1:0] xp_en,
    output logic [N_OUT-1:0]      out_en
);

    logic [CHAIN_W-1:0] chain;
    logic [CHAIN_W-1:0] held;
    load_mode_e         mode;

    assign mode = load_mode_e'(par_mode);

    xp_load_chain #(.N_OUT(N_OUT), .WORD_W(WORD_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .chip_en  (chip_en),
        .mode     (mode),
        .ser_din  (ser_din),
        .par_addr (par_addr),
        .par_data (par_data),
        .chain    (chain),
        .ser_dout (ser_dout)
    );

    xp_update_stage #(.CHAIN_W(CHAIN_W)) u_update (
        .clk      (clk),
        .rst      (rst),
        .chip_en  (chip_en),
        .hold_upd (hold_upd),
        .chain    (chain),
        .held     (held)
    );

    xp_decode #(.N_IN(N_IN), .N_OUT(N_OUT)) u_decode (
        .clk    (clk),
        .rst    (rst),
        .held   (held),
        .xp_en  (xp_en),
        .out_en (out_en)
    );

    // R9: a reset edge leaves every output off
    p_reset_off_r9: assert property (@(posedge clk)
        rst |=> (out_en == '0 && xp_en == '0));

endmodule

// File: tb/xp_matrix_cfg_tb_top.sv
`timescale 1ns/1ps
module xp_matrix_cfg_tb_top;

    localparam int NI = 16;
    localparam int NO = 16;
    localparam int CW = 80;

    logic           clk = 1'b0;
    logic           rst, chip_en, par_mode, ser_din, hold_upd;
    logic [3:0]     par_addr;
    logic [4:0]     par_data;
    logic           ser_dout;
    logic [NI*NO-1:0] xp_en;
    logic [NO-1:0]  out_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [CW-1:0] m_chain, m_held;

    always #10 clk = ~clk;

    xp_matrix_cfg dut_i (
        .clk(clk), .rst(rst), .chip_en(chip_en), .par_mode(par_mode),
        .ser_din(ser_din), .par_addr(par_addr), .par_data(par_data),
        .hold_upd(hold_upd), .ser_dout(ser_dout), .xp_en(xp_en), .out_en(out_en)
    );

    // R1/R5/R6: expected crosspoints from a held pattern
    function automatic logic [NI*NO-1:0] exp_xp(input logic [CW-1:0] h, input logic r);
        logic [NI*NO-1:0] x = '0;
        for (int o = 0; o < NO; o++) begin
            if (h[o*5+4] && !r) x[o*NI + int'(h[o*5 +: 4])] = 1'b1;
        end
        return x;
    endfunction

    function automatic logic [NO-1:0] exp_oe(input logic [CW-1:0] h, input logic r);
        logic [NO-1:0] e = '0;
        for (int o = 0; o < NO; o++) e[o] = h[o*5+4] & ~r;
        return e;
    endfunction

    task automatic check_all(input string tag);
        logic [NI*NO-1:0] ex;
        logic [NO-1:0]    eo;
        ex = exp_xp(m_held, rst);
        eo = exp_oe(m_held, rst);
        checks++;
        if (xp_en !== ex) begin
            errors++;
            $display("FAIL %s xp_en act=%h exp=%h", tag, xp_en, ex);
        end
        checks++;
        if (out_en !== eo) begin
            errors++;
            $display("FAIL %s out_en act=%h exp=%h", tag, out_en, eo);
        end
        checks++;
        if (ser_dout !== m_chain[CW-1]) begin
            errors++;
            $display("FAIL R7 %s ser_dout act=%b exp=%b", tag, ser_dout, m_chain[CW-1]);
        end
    endtask

    // drive at negedge, model at posedge, compare at the following negedge
    task automatic step(input logic r, input logic ce, input logic pm, input logic sd,
                        input logic [3:0] pa, input logic [4:0] pd, input logic hu,
                        input string tag);
        rst = r; chip_en = ce; par_mode = pm; ser_din = sd;
        par_addr = pa; par_data = pd; hold_upd = hu;
        @(posedge clk);
        if (r) begin
            m_chain = '0;
            m_held  = '0;
        end else if (ce) begin
            if (!hu) m_held = m_chain;
            if (pm) m_chain[int'(pa)*5 +: 5] = pd;
            else    m_chain = {m_chain[CW-2:0], sd};
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic load_serial(input logic [CW-1:0] cfg, input string tag);
        for (int b = CW - 1; b >= 0; b--) step(0, 1, 0, cfg[b], 4'd0, 5'd0, 1, tag);
    endtask

    logic [CW-1:0] cfg;

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        if (!done) $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        m_chain = '0; m_held = '0;
        rst = 1; chip_en = 0; par_mode = 0; ser_din = 0;
        par_addr = 0; par_data = 0; hold_upd = 1;
        @(negedge clk);
        step(1, 0, 0, 0, 0, 0, 0, "R9 reset");
        step(1, 1, 0, 1, 0, 0, 0, "R9 reset");

        // R2: serial fill under hold; R4 hold keeps outputs off
        for (int w = 0; w < 3; w++) cfg[w*32 +: 32] = $urandom;
        cfg[79] = 1'b1;
        cfg[75 +: 4] = 4'd9;
        cfg[4] = 1'b1;
        cfg[3:0] = 4'd1;
        load_serial(cfg, "R2 R4 serial fill held");
        // transfer with a harmless rewrite of slot 0 (R4 transparent)
        step(0, 1, 1, 0, 4'd0, cfg[4:0], 0, "R4 transfer");
        step(0, 1, 1, 0, 4'd0, cfg[4:0], 1, "R4 after transfer");
        checks++;
        if (out_en !== exp_oe(cfg, 0)) begin
            errors++;
            $display("FAIL R2 order out_en act=%h exp=%h", out_en, exp_oe(cfg, 0));
        end
        checks++;
        if (!(out_en[15] && xp_en[15*16 + 9] && out_en[0] && xp_en[1])) begin
            errors++;
            $display("FAIL R1 R2 first/last bit act=%b%b%b%b exp=1111",
                     out_en[15], xp_en[249], out_en[0], xp_en[1]);
        end

        // R3: parallel writes at both ends and random addresses, transparent
        step(0, 1, 1, 0, 4'd0,  5'b1_0111, 0, "R3 addr0");
        step(0, 1, 1, 0, 4'd15, 5'b1_1111, 0, "R3 addr15");
        step(0, 1, 1, 0, 4'd7,  5'b0_0011, 0, "R6 disable out7");
        step(0, 1, 1, 0, 4'd7,  5'b0_0011, 0, "R6 disable out7 seen");
        for (int n = 0; n < 200; n++)
            step(0, 1, 1, 0, 4'($urandom), 5'($urandom), 0, "R3 R5 random write");

        // R8: chip enable low, every other input toggles
        for (int n = 0; n < 200; n++)
            step(0, 0, 1'($urandom), 1'($urandom), 4'($urandom), 5'($urandom),
                 1'($urandom), "R8 idle");

        // R9: reset in the middle of traffic, then idle transparent
        step(1, 1, 1, 0, 4'd3, 5'b1_0010, 0, "R9 mid reset");
        step(0, 0, 0, 0, 4'd3, 5'b1_0010, 0, "R9 after reset");

        // random mix of all modes
        for (int n = 0; n < 3000; n++) begin
            logic r;
            r = ($urandom % 100) == 0;
            step(r, 1'(($urandom % 8) != 0), 1'($urandom), 1'($urandom),
                 4'($urandom), 5'($urandom), 1'(($urandom % 4) == 0), "R2 R3 R4 R5 mix");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule